// File: doc/BRIEF.md
# Divide Operand Screening Unit

This unit inspects a dividend and a divisor, both IEEE-754 double-precision words, before a software or iterative divide routine uses them. It reports two flags. The exception flag says the quotient may need special handling. The guard flag says the divisor is too small for the fast path. Both flags are packed into a 4-bit condition value that a branch can test. The unit does not divide and does not round.

An operation is issued by pulsing `in_valid` with both operands present. If `fpu_en` is high at that edge, the condition value and `out_valid` appear one clock later. If `fpu_en` is low, no condition value is produced. Instead `fpu_unavail` pulses for one cycle at the same point in time. The sign bits of both operands have no effect on either flag.

Top module: `fdiv_screen`

## Requirements
- R1: An issue with `fpu_en` high makes `out_valid` high for exactly the following cycle, with `out_cc` valid in that cycle. A cycle without an issue is followed by `out_valid` low.
- R2: If the dividend is infinite, the divisor is infinite, or the divisor is zero, both flags are set (`out_cc` = 4'b1110). This holds whatever the other tests would give.
- R3: Otherwise, a NaN in either operand sets the exception flag. A NaN is an exponent field of all ones with a nonzero fraction, and it may be quiet or signalling.
- R4: Otherwise, the exception flag is set when the divisor's unbiased exponent (field at bits 62:52 minus 1023) is at most -1022 or at least 1021.
- R5: Otherwise, for a nonzero dividend, the exception flag is set when any of these holds: the dividend exponent minus the divisor exponent is at least 1023; that difference is at most -1021; the dividend exponent is at most -970. A zero dividend never triggers these tests.
- R6: Outside the R2 case, the guard flag is set exactly when the divisor's exponent field is zero, which means the divisor is denormal.
- R7: `out_cc` is {1, guard, exception, 0}: bit 3 is always 1, bit 2 is the guard flag, bit 1 is the exception flag, and bit 0 is 0.
- R8: An issue with `fpu_en` low makes `fpu_unavail` high for exactly the following cycle, and `out_valid` stays low in that cycle.
- R9: The sign bit of either operand has no effect on `out_cc`.
- R10: A synchronous active-high `rst` clears `out_valid` and `fpu_unavail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| fpu_en | input | 1 | Floating-point unit enabled at issue |
| dividend | input | 64 | Dividend, double precision |
| divisor | input | 64 | Divisor, double precision |
| out_valid | output | 1 | Condition value valid |
| out_cc | output | 4 | Condition value {1, guard, exception, 0} |
| fpu_unavail | output | 1 | Pulse: issue refused, unit disabled |

## Verification
Several tests can be true for one operand pair. An infinite dividend can meet a NaN divisor, a NaN dividend can meet a zero divisor, and a denormal divisor meets the low-exponent test. The bench builds these pairs on purpose and expects the top-priority outcome. The issue path and the refusal path also land in adjacent cycles: the bench issues back to back while toggling `fpu_en`. A scoreboard then checks that each cycle carries exactly one of `out_valid` and `fpu_unavail`, and that they come in issue order.

// File: rtl/fdiv_screen.sv
module fdiv_screen (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        fpu_en,
  input  logic [63:0] dividend,
  input  logic [63:0] divisor,
  output logic        out_valid,
  output logic [3:0]  out_cc,
  output logic        fpu_unavail
);
  localparam int EW = 11;
  localparam int FW = 52;
  localparam int XW = EW + 1;
  localparam logic signed [XW-1:0] BIAS    = XW'(1023);
  localparam logic signed [XW-1:0] B_LO    = -XW'(1022);
  localparam logic signed [XW-1:0] B_HI    = XW'(1021);
  localparam logic signed [XW-1:0] D_HI    = XW'(1023);
  localparam logic signed [XW-1:0] D_LO    = -XW'(1021);
  localparam logic signed [XW-1:0] A_FLOOR = -XW'(970);

  logic [EW-1:0] xa, xb;
  logic [FW-1:0] fa, fb;
  assign xa = dividend[FW+EW-1:FW];
  assign xb = divisor[FW+EW-1:FW];
  assign fa = dividend[FW-1:0];
  assign fb = divisor[FW-1:0];

  logic unused_signs;
  assign unused_signs = dividend[63] ^ divisor[63];

  logic top_a, top_b, inf_a, inf_b, nan_a, nan_b, zero_a, zero_b;
  assign top_a  = &xa;
  assign top_b  = &xb;
  assign inf_a  = top_a && (fa == '0);
  assign inf_b  = top_b && (fb == '0);
  assign nan_a  = top_a && (fa != '0);
  assign nan_b  = top_b && (fb != '0);
  assign zero_a = (xa == '0) && (fa == '0);
  assign zero_b = (xb == '0) && (fb == '0);

  logic signed [XW-1:0] ea, eb, ed;
  assign ea = $signed({1'b0, xa}) - BIAS;
  assign eb = $signed({1'b0, xb}) - BIAS;
  assign ed = ea - eb;

  logic special, b_range, a_range, flag_e, flag_g;
  assign special = inf_a || inf_b || zero_b;
  assign b_range = (eb <= B_LO) || (eb >= B_HI);
  assign a_range = !zero_a && ((ed >= D_HI) || (ed <= D_LO) || (ea <= A_FLOOR));
  assign flag_e  = special || nan_a || nan_b || b_range || a_range;
  assign flag_g  = special || (xb == '0);

  logic go, refuse;
  assign go     = in_valid && fpu_en;
  assign refuse = in_valid && !fpu_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      fpu_unavail <= 1'b0;
      out_cc      <= 4'b0000;
    end else begin
      out_valid   <= go;
      fpu_unavail <= refuse;
      if (go) out_cc <= {1'b1, flag_g, flag_e, 1'b0};
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    go |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !fpu_unavail));
  p_special_r2: assert property (@(posedge clk) disable iff (rst)
    (go && special) |=> (out_cc[2:1] == 2'b11));
  p_format_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cc[3] && !out_cc[0]));
  p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    refuse |=> (fpu_unavail && !out_valid));
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && fpu_unavail));
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && !fpu_unavail));
endmodule

// File: tb/sim_fdiv_screen.sv
`timescale 1ns/1ps
module sim_fdiv_screen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic fpu_en = 1'b1;
  logic [63:0] dividend = '0;
  logic [63:0] divisor = '0;
  logic out_valid, fpu_unavail;
  logic [3:0] out_cc;

  always #2 clk = ~clk;

  fdiv_screen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fpu_en(fpu_en),
    .dividend(dividend), .divisor(divisor),
    .out_valid(out_valid), .out_cc(out_cc), .fpu_unavail(fpu_unavail)
  );

  int checks = 0;
  int fails = 0;
  logic       q_unav[$];
  logic [3:0] q_cc[$];
  string      q_tag[$];

  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [3:0]  CC_N  = 4'b1000;
  localparam logic [3:0]  CC_E  = 4'b1010;
  localparam logic [3:0]  CC_GE = 4'b1110;

  task automatic issue(input logic [63:0] a, input logic [63:0] b,
                       input logic en, input logic [3:0] cc, input string tag);
    @(negedge clk);
    dividend = a; divisor = b; fpu_en = en; in_valid = 1'b1;
    q_unav.push_back(!en); q_cc.push_back(cc); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (out_valid || fpu_unavail)) begin
      checks++;
      if (q_cc.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected output: out_valid=%0b fpu_unavail=%0b expected none",
                 out_valid, fpu_unavail);
      end else begin
        logic u; logic [3:0] c; string t;
        u = q_unav.pop_front(); c = q_cc.pop_front(); t = q_tag.pop_front();
        if (u) begin
          if (!(fpu_unavail && !out_valid)) begin
            fails++;
            $display("FAIL %s: fpu_unavail=%0b out_valid=%0b expected 1/0",
                     t, fpu_unavail, out_valid);
          end
        end else if (!(out_valid && !fpu_unavail && out_cc == c)) begin
          fails++;
          $display("FAIL %s: out_valid=%0b out_cc=%b expected 1 and %b",
                   t, out_valid, out_cc, c);
        end
      end
    end
  end

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || fpu_unavail !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: out_valid=%0b fpu_unavail=%0b expected 0/0",
               out_valid, fpu_unavail);
    end
    rst = 1'b0;
    idle(2);

    // R2 priority cases
    issue(PINF, PINF, 1'b1, CC_GE, "R2 both infinite");
    issue(ONE, 64'h0, 1'b1, CC_GE, "R2 divisor +0");
    issue(ONE, 64'h8000_0000_0000_0000, 1'b1, CC_GE, "R2 divisor -0");
    issue(PINF, QNAN, 1'b1, CC_GE, "R2 inf dividend over NaN divisor");
    issue(SNAN, 64'h0, 1'b1, CC_GE, "R2 zero divisor over NaN dividend");
    // R3 NaN
    issue(ONE, QNAN, 1'b1, CC_E, "R3 quiet NaN divisor");
    issue(SNAN, ONE, 1'b1, CC_E, "R3 signalling NaN dividend");
    // R4 divisor exponent edges
    issue(ONE, 64'h0010_0000_0000_0000, 1'b1, CC_E, "R4 divisor exp -1022");
    issue(ONE, 64'h0020_0000_0000_0000, 1'b1, CC_N, "R4 divisor exp -1021");
    issue(64'h7FA0_0000_0000_0000, 64'h7FC0_0000_0000_0000, 1'b1, CC_E, "R4 divisor exp 1021");
    issue(ONE, 64'h7FB0_0000_0000_0000, 1'b1, CC_N, "R4 divisor exp 1020");
    // R5 difference and floor
    issue(64'h7FD0_0000_0000_0000, 64'h3FE0_0000_0000_0000, 1'b1, CC_E, "R5 diff 1023");
    issue(64'h7FC0_0000_0000_0000, 64'h3FE0_0000_0000_0000, 1'b1, CC_N, "R5 diff 1022");
    issue(64'h3FE0_0000_0000_0000, 64'h7FB0_0000_0000_0000, 1'b1, CC_E, "R5 diff -1021");
    issue(64'h0350_0000_0000_0000, ONE, 1'b1, CC_E, "R5 dividend exp -970");
    issue(64'h0360_0000_0000_0000, ONE, 1'b1, CC_N, "R5 dividend exp -969");
    issue(64'h0, 64'h7FB0_0000_0000_0000, 1'b1, CC_N, "R5 zero dividend suppresses tests");
    issue(64'h8000_0000_0000_0000, ONE, 1'b1, CC_N, "R5 negative zero dividend");
    // R6 denormal divisor
    issue(ONE, 64'h0000_0000_0000_0001, 1'b1, CC_GE, "R6 denormal divisor");
    // R9 signs
    issue(64'hBFF0_0000_0000_0000, 64'h8000_0000_0000_0001, 1'b1, CC_GE, "R9 negative denormal divisor");
    issue(64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b1, CC_N, "R9 negative normal operands");
    issue(64'hFFF0_0000_0000_0000, ONE, 1'b1, CC_GE, "R9 negative infinite dividend");
    // R8 refusal interleaved with issues (R7 format checked with every result)
    issue(ONE, ONE, 1'b0, CC_N, "R8 disabled issue");
    issue(ONE, ONE, 1'b1, CC_N, "R7 normal after refusal");
    issue(PINF, ONE, 1'b0, CC_N, "R8 disabled special issue");
    issue(ONE, QNAN, 1'b1, CC_E, "R1 back-to-back result");
    idle(1);
    issue(ONE, ONE, 1'b0, CC_N, "R8 isolated refusal");
    idle(6);

    checks++;
    if (q_cc.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results: pending=%0d expected 0", q_cc.size());
    end

    // R10 reset mid-stream: result of last issue must not appear
    @(negedge clk);
    dividend = ONE; divisor = ONE; fpu_en = 1'b1; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || fpu_unavail !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset during issue: out_valid=%0b fpu_unavail=%0b expected 0/0",
               out_valid, fpu_unavail);
    end
    rst = 1'b0;
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule